// File: doc/BRIEF.md
# Synchronous Slave FIFO Read Sequencer

This block sits on the master side of a synchronous slave FIFO link. It takes a read request that carries a FIFO address and a word count. It then drives the slave's address, chip select, output enable and read strobe in a fixed phase order. Each word the slave returns comes out on a valid/data stream. When the bus has been released, the block pulses a completion signal that carries the number of words received.

The address and chip select come up first and are held for a parameterised number of setup cycles. These cycles stand in for the slave's address setup time. Output enable follows one cycle later, and the read strobe one cycle after that. The strobe is then held for one cycle per word, so a single-word read and a burst follow the same sequence. On release, the strobe drops first. Output enable drops one cycle later, and the address and chip select are held for a parameterised number of hold cycles. If the slave reports empty while the strobe is high, no word is taken, the strobe is released at once and the completion is flagged as short.

Top module: `sfifo_rd_seq`

## Requirements
- R1: After reset, `req_ready` is 1 and `bus_cs`, `bus_oe`, `bus_rd`, `word_valid` and `done` are all 0.
- R2: A request is accepted on a rising edge where `req_valid` is 1, `req_ready` is 1 and `req_len` is nonzero. A request with `req_len` = 0 is ignored and `bus_cs` stays 0. `req_ready` is 0 from acceptance until the end of the hold phase, and a request presented in that time is ignored.
- R3: `bus_cs` rises in the cycle after acceptance, with `bus_addr` equal to the accepted address. `bus_addr` stays constant while `bus_cs` is 1. Exactly `SETUP_CYC` cycles have `bus_cs` = 1 and `bus_oe` = 0 before `bus_oe` rises.
- R4: `bus_oe` is 1 for exactly one cycle before `bus_rd` rises. `bus_rd` is never 1 without `bus_oe`, and `bus_oe` is never 1 without `bus_cs`.
- R5: When the slave holds at least `req_len` words, `bus_rd` stays 1 for exactly `req_len` consecutive cycles. One word is taken at each rising edge where `bus_rd` is 1 and `bus_empty` is 0. That word is presented on `word_data` with `word_valid` = 1 in the following cycle. Words come out in FIFO order.
- R6: On release, `bus_oe` stays 1 for exactly one cycle after `bus_rd` falls. `bus_cs` and `bus_addr` then stay asserted for exactly `HOLD_CYC` cycles with `bus_oe` = 0.
- R7: At a rising edge where `bus_rd` is 1 and `bus_empty` is 1, no word is taken and `word_valid` is 0 in the next cycle. `bus_rd` is 0 in the next cycle, the release sequence of R6 follows, and the completion reports `done_short` = 1.
- R8: `done` is a single-cycle pulse in the cycle after `bus_cs` falls, with `req_ready` = 1. At the pulse, `done_words` equals the number of words delivered, and `done_short` is 0 when that number equals the requested length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, a request can be accepted |
| req_addr | input | AW | FIFO address for the request |
| req_len | input | CW | Words to read (0 is ignored) |
| bus_addr | output | AW | FIFO address driven to the slave |
| bus_cs | output | 1 | Chip select (1 = asserted) |
| bus_oe | output | 1 | Output enable (1 = slave drives data) |
| bus_rd | output | 1 | Read strobe (1 = advance slave pointer) |
| bus_empty | input | 1 | Slave empty flag for the addressed FIFO |
| bus_data | input | DW | Data bus from the slave |
| word_valid | output | 1 | Received word valid |
| word_data | output | DW | Received word |
| done | output | 1 | Transfer complete pulse |
| done_short | output | 1 | Transfer ended on empty before the full length |
| done_words | output | CW | Words delivered in the transfer |

## Verification
A phase counter loaded with the wrong value changes the number of setup or hold cycles, and the bench's per-phase cycle counts report it in that same transfer. A word counter that is off by one shows up in the strobe length and in `done_words` at the next completion. A capture gated on the wrong condition shows up on the very next `word_valid` cycle, either as an out-of-order or duplicated word or as a word taken while the slave was empty. Ordering faults among chip select, output enable and strobe break a cycle-level property on the cycle they occur.

// File: rtl/sfrd_pkg.sv
package sfrd_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SETUP = 3'd1,
        PH_OE    = 3'd2,
        PH_READ  = 3'd3,
        PH_DROP  = 3'd4,
        PH_HOLD  = 3'd5
    } phase_e;

    typedef struct packed {
        logic cs;
        logic oe;
        logic rd;
    } strobe_t;

    // Bus strobe levels for each phase of the read sequence.
    function automatic strobe_t strobes_of(phase_e p);
        strobe_t s;
        s = '0;
        case (p)
            PH_SETUP: s = '{cs: 1'b1, oe: 1'b0, rd: 1'b0};
            PH_OE:    s = '{cs: 1'b1, oe: 1'b1, rd: 1'b0};
            PH_READ:  s = '{cs: 1'b1, oe: 1'b1, rd: 1'b1};
            PH_DROP:  s = '{cs: 1'b1, oe: 1'b1, rd: 1'b0};
            PH_HOLD:  s = '{cs: 1'b1, oe: 1'b0, rd: 1'b0};
            default:  s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sfrd_timer.sv
module sfrd_timer #(
    parameter int TW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] val,
    output logic          zero
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/sfrd_capture.sv
module sfrd_capture #(
    parameter int DW = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] len,
    input  logic          take,
    input  logic [DW-1:0] data,
    output logic          last,
    output logic [CW-1:0] got,
    output logic          vld,
    output logic [DW-1:0] dat
);
    logic [CW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            left <= '0;
            got  <= '0;
            vld  <= 1'b0;
            dat  <= '0;
        end else begin
            vld <= take;
            if (start) begin
                left <= len;
                got  <= '0;
            end else if (take) begin
                left <= left - 1'b1;
                got  <= got + 1'b1;
                dat  <= data;
            end
        end
    end

    assign last = (left == CW'(1));
endmodule

// File: rtl/sfifo_rd_seq.sv
module sfifo_rd_seq #(
    parameter int AW        = 6,
    parameter int DW        = 8,
    parameter int CW        = 8,
    parameter int SETUP_CYC = 2,
    parameter int HOLD_CYC  = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [CW-1:0] req_len,
    output logic [AW-1:0] bus_addr,
    output logic          bus_cs,
    output logic          bus_oe,
    output logic          bus_rd,
    input  logic          bus_empty,
    input  logic [DW-1:0] bus_data,
    output logic          word_valid,
    output logic [DW-1:0] word_data,
    output logic          done,
    output logic          done_short,
    output logic [CW-1:0] done_words
);
    import sfrd_pkg::*;

    localparam int TMAX = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
    localparam int TW   = $clog2(TMAX + 1);

    phase_e        ph, ph_nx;
    strobe_t       stb;
    logic          accept, take, last;
    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;

    assign accept = (ph == PH_IDLE) && req_valid && (req_len != '0);
    assign take   = (ph == PH_READ) && !bus_empty;

    always_comb begin
        ph_nx    = ph;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (ph)
            PH_IDLE: if (accept) begin
                ph_nx    = PH_SETUP;
                tmr_load = 1'b1;
                tmr_val  = TW'(SETUP_CYC - 1);
            end
            PH_SETUP: if (tmr_zero) ph_nx = PH_OE;
            PH_OE:    ph_nx = PH_READ;
            PH_READ:  if (bus_empty || last) ph_nx = PH_DROP;
            PH_DROP: begin
                ph_nx    = PH_HOLD;
                tmr_load = 1'b1;
                tmr_val  = TW'(HOLD_CYC - 1);
            end
            PH_HOLD:  if (tmr_zero) ph_nx = PH_IDLE;
            default:  ph_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph         <= PH_IDLE;
            bus_addr   <= '0;
            done       <= 1'b0;
            done_short <= 1'b0;
        end else begin
            ph   <= ph_nx;
            done <= (ph == PH_HOLD) && tmr_zero;
            if (accept) begin
                bus_addr   <= req_addr;
                done_short <= 1'b0;
            end else if ((ph == PH_READ) && bus_empty) begin
                done_short <= 1'b1;
            end
        end
    end

    sfrd_timer #(.TW(TW)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (tmr_load),
        .val  (tmr_val),
        .zero (tmr_zero)
    );

    sfrd_capture #(.DW(DW), .CW(CW)) u_cap (
        .clk   (clk),
        .rst   (rst),
        .start (accept),
        .len   (req_len),
        .take  (take),
        .data  (bus_data),
        .last  (last),
        .got   (done_words),
        .vld   (word_valid),
        .dat   (word_data)
    );

    assign stb       = strobes_of(ph);
    assign bus_cs    = stb.cs;
    assign bus_oe    = stb.oe;
    assign bus_rd    = stb.rd;
    assign req_ready = (ph == PH_IDLE);
endmodule

// File: rtl/sfrd_chk.sv
module sfrd_chk #(
    parameter int AW = 6,
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_ready,
    input logic [CW-1:0] req_len,
    input logic [AW-1:0] bus_addr,
    input logic          bus_cs,
    input logic          bus_oe,
    input logic          bus_rd,
    input logic          bus_empty,
    input logic          word_valid,
    input logic          done
);
    // R4
    rd_needs_oe_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rd |-> bus_oe);
    // R4
    oe_needs_cs_chk: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> bus_cs);
    // R4
    rd_after_oe_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_rd) |-> $past(bus_oe));
    // R3
    addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_cs && $past(bus_cs)) |-> $stable(bus_addr));
    // R6
    oe_outlasts_rd_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_rd) |-> bus_oe);
    // R2
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_len != '0) |=> bus_cs);
    // R5
    word_src_chk: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> $past(bus_rd && !bus_empty));
    // R7
    no_word_on_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_empty) |=> (!word_valid && !bus_rd));
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (req_ready && !bus_cs && $past(bus_cs)));
endmodule

bind sfifo_rd_seq sfrd_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_len    (req_len),
    .bus_addr   (bus_addr),
    .bus_cs     (bus_cs),
    .bus_oe     (bus_oe),
    .bus_rd     (bus_rd),
    .bus_empty  (bus_empty),
    .word_valid (word_valid),
    .done       (done)
);

// File: tb/sfifo_rd_seq_tb.sv
module sfifo_rd_seq_tb;
    localparam int AW = 6, DW = 8, CW = 8, S = 3, H = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          req_valid = 1'b0, req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [CW-1:0] req_len = '0;
    logic [AW-1:0] bus_addr;
    logic          bus_cs, bus_oe, bus_rd, bus_empty;
    logic [DW-1:0] bus_data;
    logic          word_valid, done, done_short;
    logic [DW-1:0] word_data;
    logic [CW-1:0] done_words;

    sfifo_rd_seq #(.AW(AW), .DW(DW), .CW(CW), .SETUP_CYC(S), .HOLD_CYC(H)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .bus_addr(bus_addr),
        .bus_cs(bus_cs), .bus_oe(bus_oe), .bus_rd(bus_rd), .bus_empty(bus_empty),
        .bus_data(bus_data), .word_valid(word_valid), .word_data(word_data),
        .done(done), .done_short(done_short), .done_words(done_words)
    );

    // Slave FIFO model: prefetched word on the bus while output enabled.
    logic [7:0] mem [0:15];
    int ptr = 0;
    int avail = 0;
    logic slv_clr = 1'b0;
    assign bus_empty = (ptr >= avail);
    assign bus_data  = bus_oe ? mem[ptr[3:0]] : 8'h00;
    always @(posedge clk) begin
        if (slv_clr) ptr <= 0;
        else if (bus_cs && bus_rd && !bus_empty) ptr <= ptr + 1;
    end

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0, bad = 0;
    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int min2(int a, int b);
        return (a < b) ? a : b;
    endfunction

    function automatic int rd_cycles(int len, int av);
        return (av >= len) ? len : av + 1;
    endfunction

    // Expected transfer, set by the driver.
    int exp_len = 0, exp_avail = 0, a_cyc = 0;
    logic [AW-1:0] exp_addr = '0;

    // Monitor
    int pre = 0, oe_pre = 0, rdc = 0, oe_post = 0, post = 0, widx = 0;
    bit seen_rd = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (bus_rd && !bus_oe) chk(0, "R4 rd without oe", 1, 0);
            if (bus_oe && !bus_cs) chk(0, "R4 oe without cs", 1, 0);
            if (bus_cs && bus_addr != exp_addr)
                chk(0, "R3 address", int'(bus_addr), int'(exp_addr));
            if (bus_cs && !bus_oe && !seen_rd) pre++;
            if (bus_oe && !bus_rd && !seen_rd) oe_pre++;
            if (bus_rd) begin rdc++; seen_rd = 1; end
            if (bus_oe && !bus_rd && seen_rd) oe_post++;
            if (bus_cs && !bus_oe && seen_rd) post++;
            if (word_valid) begin
                chk(word_data == mem[widx[3:0]], "R5 word order", int'(word_data),
                    int'(mem[widx[3:0]]));
                widx++;
            end
            if (done) begin
                chk(cyc == a_cyc + S + 2 + rd_cycles(exp_len, exp_avail) + H,
                    "R8 done timing", cyc - a_cyc, S + 2 + rd_cycles(exp_len, exp_avail) + H);
                chk(req_ready, "R8 ready at done", int'(req_ready), 1);
                chk(widx == min2(exp_len, exp_avail), "R5 words delivered", widx,
                    min2(exp_len, exp_avail));
                chk(int'(done_words) == min2(exp_len, exp_avail), "R8 done_words",
                    int'(done_words), min2(exp_len, exp_avail));
                chk(done_short == (exp_avail < exp_len), "R7 done_short",
                    int'(done_short), int'(exp_avail < exp_len));
                chk(pre == S, "R3 setup cycles", pre, S);
                chk(oe_pre == 1, "R4 oe lead", oe_pre, 1);
                chk(rdc == rd_cycles(exp_len, exp_avail), "R5 strobe length", rdc,
                    rd_cycles(exp_len, exp_avail));
                chk(oe_post == 1, "R6 oe trail", oe_post, 1);
                chk(post == H, "R6 hold cycles", post, H);
                pre = 0; oe_pre = 0; rdc = 0; oe_post = 0; post = 0; widx = 0; seen_rd = 0;
            end
        end
    end

    task automatic run_xfer(int addr, int len, int av, bit poke);
        @(negedge clk);
        for (int i = 0; i < 16; i++) mem[i] = 8'($urandom);
        exp_len = len; exp_avail = av; exp_addr = AW'(addr);
        avail = av;
        slv_clr = 1'b1;
        @(negedge clk);
        slv_clr = 1'b0;
        req_valid = 1'b1; req_addr = AW'(addr); req_len = CW'(len);
        @(posedge clk);
        #1 a_cyc = cyc;
        req_valid = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            req_valid = 1'b1; req_addr = ~AW'(addr); req_len = CW'(3);
            chk(!req_ready, "R2 busy not ready", int'(req_ready), 0);
            @(negedge clk);
            req_valid = 1'b0;
        end
        @(negedge clk);
        while (!done) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(req_ready && !bus_cs && !bus_oe && !bus_rd && !word_valid && !done,
            "R1 reset state", {req_ready, bus_cs, bus_oe, bus_rd, word_valid, done}, 6'b100000);
        // R2 zero length ignored
        req_valid = 1'b1; req_len = '0; req_addr = 6'h15;
        @(negedge clk);
        chk(req_ready && !bus_cs, "R2 zero length ignored", int'(bus_cs), 0);
        req_valid = 1'b0;
        @(negedge clk);
        chk(!bus_cs && !done, "R2 zero length no transfer", int'(done), 0);
        // Directed corners
        run_xfer(6'h01, 1, 5, 0);   // R5 single word
        run_xfer(6'h22, 8, 8, 0);   // R5 exact fill
        run_xfer(6'h13, 6, 3, 0);   // R7 short burst
        run_xfer(6'h3f, 4, 0, 0);   // R7 empty from start
        run_xfer(6'h0a, 5, 9, 1);   // R2 request while busy ignored
        run_xfer(6'h2c, 10, 12, 0); // R6 long burst release
        for (int n = 0; n < 40; n++)
            run_xfer(int'($urandom % 64), 1 + int'($urandom % 10), int'($urandom % 13),
                     ($urandom % 4) == 0);
        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule